// File: doc/BRIEF.md
# Command-Driven Random Block Generator

This block is a random number peripheral on a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. Software writes a command word to start one of two engine operations. A reseed stirs an external noise word into a 32-bit LFSR over a fixed run of cycles. A generate steps the LFSR once per output word and stores each new state in a bank of result words. The result is 256 bits (eight words) or 128 bits (four words), chosen by a mode bit.

Software polls two busy bits in a status word, or waits for an interrupt. Three event flags record a finished generate, a finished reseed and an LFSR that collapsed to zero. Each flag is cleared by writing a one to it. The interrupt line is gated by a global enable and by one enable for each source. Two automatic-reseed registers are plain storage that software reads back; they have no effect on the engine.

Top module: `rng_ctrl`

## Requirements
- R1: After reset, all registers read 0: status, mode, interrupt enable, event flags and all result words. The irq output is low.
- R2: A write to offset 0x00 with value 1 starts a generate and value 2 starts a reseed. Any other value does nothing. Offset 0x00 reads 0.
- R3: A reseed lasts 16 cycles with status bit 31 set. Each cycle applies s = step(s) XOR noise_in, where step(s) = (s<<1) XOR (s[31] ? 0x04C11DB7 : 0). The LFSR starts at 0xACE12468 after reset. A finished reseed sets status bit 9, which stays set, and event bit 1.
- R4: A generate lasts one cycle per word with status bit 30 set. Word k (offset 0x20+4k, k counting from 0) receives step applied k+1 times to the starting state. A finished generate sets event bit 0.
- R5: Mode register bit 3 (offset 0x08) set gives 8 words. Bit 3 clear gives 4 words, and words 4 to 7 keep their values. Status bit 3 mirrors the mode bit.
- R6: Command writes that arrive while the engine is busy are ignored. The run in progress keeps its length and its result.
- R7: A generate issued before the first reseed has completed is ignored: the engine does not go busy, no event flag is set and the words are unchanged.
- R8: If an LFSR update would give zero, the state becomes 0x00000001 instead and event bit 4 is set.
- R9: Event flags at offset 0x14 are write-one-to-clear. Writing 0 to a bit leaves it set.
- R10: irq is high exactly when enable bit 31 (offset 0x10) is set and, for at least one i in {0,1,4}, both enable bit i and event bit i are set.
- R11: Offsets 0x60 and 0x64 hold full 32-bit values that read back. Their contents do not change generation.
- R12: The enable register reads back only bits 0, 1, 4 and 31, and the mode register only bit 3. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| noise_in | input | 32 | Entropy word mixed in on each reseed cycle |
| irq | output | 1 | Interrupt request |

## Verification
The bench counts busy cycles for both operations, at both widths. This catches an engine that is off by one word or one reseed cycle, and one that ignores the latched width. A second command written during a reseed must not shorten the run or restart it; a design that accepted it would finish with the wrong busy count and a different LFSR state. A generate before seeding must leave the words and flags untouched, and the noise word is chosen so that the first reseed step gives zero. A design without the lock-up rescue would then stick at zero and read all-zero words. The bench also checks the interrupt gate under each combination of global enable, source enable and pending flag, and checks write-one-to-clear against writes of zero.

// File: rtl/rng_pkg.sv
// Package: register offsets, bit positions, engine states and the LFSR step
// shared by the random block generator. Assumes a 32-bit data path.
package rng_pkg;
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_STAT  = 8'h04;
    localparam logic [7:0] OFS_MODE  = 8'h08;
    localparam logic [7:0] OFS_IEN   = 8'h10;
    localparam logic [7:0] OFS_EVT   = 8'h14;
    localparam logic [7:0] OFS_WORD0 = 8'h20;
    localparam logic [7:0] OFS_AREQ  = 8'h60;
    localparam logic [7:0] OFS_AAGE  = 8'h64;

    localparam int B_WIDE    = 3;
    localparam int B_SEEDED  = 9;
    localparam int B_GENBUSY = 30;
    localparam int B_SEEDBSY = 31;
    localparam int B_RDY     = 0;
    localparam int B_SDONE   = 1;
    localparam int B_LOCK    = 4;
    localparam int B_GLOBAL  = 31;

    localparam logic [31:0] CMD_GEN  = 32'd1;
    localparam logic [31:0] CMD_SEED = 32'd2;
    localparam logic [31:0] IEN_MASK = 32'h8000_0013;

    typedef enum logic [1:0] {ENG_IDLE, ENG_GEN, ENG_SEED} eng_state_t;

    // One Galois step of the left-shifting LFSR.
    function automatic logic [31:0] lfsr_step(input logic [31:0] s, input logic [31:0] poly);
        return {s[30:0], 1'b0} ^ (s[31] ? poly : 32'h0);
    endfunction
endpackage

// File: rtl/rng_lfsr.sv
// LFSR entropy state. Advances one step when adv is high. In mix mode the
// noise word is XORed into the step result. A zero result is replaced by
// FILL and flagged. Assumes INIT and FILL are nonzero.
module rng_lfsr
    import rng_pkg::*;
#(
    parameter logic [31:0] POLY = 32'h04C1_1DB7,
    parameter logic [31:0] INIT = 32'hACE1_2468,
    parameter logic [31:0] FILL = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    input  logic        mix,
    input  logic [31:0] noise,
    output logic [31:0] next_state,
    output logic        lock_evt
);
    logic [31:0] state_q;
    logic [31:0] raw;

    // Next-state computation with the zero rescue.
    always_comb begin
        raw        = lfsr_step(state_q, POLY) ^ (mix ? noise : 32'h0);
        lock_evt   = adv && (raw == 32'h0);
        next_state = (raw == 32'h0) ? FILL : raw;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)   state_q <= INIT;
        else if (adv) state_q <= next_state;
    end

    p_state_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 32'h0);
    p_lock_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_evt |=> (state_q == FILL));
endmodule

// File: rtl/rng_seq.sv
// Engine sequencer: accepts generate or reseed only when idle, runs a fixed
// count (one cycle per word, or SEED_CYCLES) and pulses a done strobe on the
// last cycle. A generate is accepted only after a reseed has completed.
module rng_seq
    import rng_pkg::*;
#(
    parameter int WORDS       = 8,
    parameter int SEED_CYCLES = 16,
    localparam int MAXC  = (WORDS > SEED_CYCLES) ? WORDS : SEED_CYCLES,
    localparam int CNT_W = $clog2(MAXC),
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_gen,
    input  logic             start_seed,
    input  logic             wide,
    output logic             busy_gen,
    output logic             busy_seed,
    output logic             adv,
    output logic             mix,
    output logic             word_we,
    output logic [IDX_W-1:0] word_idx,
    output logic             gen_done,
    output logic             seed_done,
    output logic             seeded
);
    eng_state_t       st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             last;

    // Decoded controls for the datapath.
    always_comb begin
        last      = (cnt == lim);
        busy_gen  = (st == ENG_GEN);
        busy_seed = (st == ENG_SEED);
        adv       = (st != ENG_IDLE);
        mix       = busy_seed;
        word_we   = busy_gen;
        word_idx  = cnt[IDX_W-1:0];
        gen_done  = busy_gen && last;
        seed_done = busy_seed && last;
    end

    // State, cycle counter, latched run length and sticky seeded flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ENG_IDLE;
            cnt    <= '0;
            lim    <= '0;
            seeded <= 1'b0;
        end else begin
            case (st)
                ENG_IDLE: begin
                    cnt <= '0;
                    if (start_seed) begin
                        st  <= ENG_SEED;
                        lim <= CNT_W'(SEED_CYCLES - 1);
                    end else if (start_gen && seeded) begin
                        st  <= ENG_GEN;
                        lim <= wide ? CNT_W'(WORDS - 1) : CNT_W'(WORDS / 2 - 1);
                    end
                end
                default: begin
                    if (last) begin
                        st <= ENG_IDLE;
                        if (st == ENG_SEED) seeded <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    p_run_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ENG_IDLE && !last) |=> (st == $past(st) && cnt == $past(cnt) + 1'b1));
    p_seeded_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seeded |=> seeded);
    p_unseeded_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENG_IDLE && start_gen && !start_seed && !seeded) |=> (st == ENG_IDLE));
endmodule

// File: rtl/rng_ctrl.sv
// Register-mapped random block generator. Decodes bus writes into commands,
// mode, enables and W1C event flags, stores the result words and muxes reads.
// Assumes DATA_W = 32, WORDS = 8 and a result window aligned to 32 bytes.
module rng_ctrl
    import rng_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 32,
    parameter int          WORDS       = 8,
    parameter int          SEED_CYCLES = 16,
    parameter logic [31:0] POLY        = 32'h04C1_1DB7,
    parameter logic [31:0] SEED_INIT   = 32'hACE1_2468,
    parameter logic [31:0] LOCK_FILL   = 32'h0000_0001,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] noise_in,
    output logic              irq
);
    logic              start_gen, start_seed;
    logic              busy_gen, busy_seed, adv, mix, word_we;
    logic              gen_done, seed_done, seeded, lock_evt;
    logic [IDX_W-1:0]  word_idx;
    logic [DATA_W-1:0] next_state;
    logic              wide_q;
    logic [DATA_W-1:0] ien_q, areq_q, aage_q;
    logic [2:0]        evt_q;
    logic [2:0]        evt_clr;
    logic [2:0]        ien_src;
    logic [DATA_W-1:0] word_q [WORDS];
    logic              in_words;

    // Command and flag-clear decode.
    always_comb begin
        start_gen  = bus_we && (bus_addr == OFS_CTRL) && (bus_wdata == CMD_GEN);
        start_seed = bus_we && (bus_addr == OFS_CTRL) && (bus_wdata == CMD_SEED);
        evt_clr    = (bus_we && bus_addr == OFS_EVT) ?
                     {bus_wdata[B_LOCK], bus_wdata[B_SDONE], bus_wdata[B_RDY]} : 3'b000;
        ien_src    = {ien_q[B_LOCK], ien_q[B_SDONE], ien_q[B_RDY]};
        irq        = ien_q[B_GLOBAL] && ((ien_src & evt_q) != 3'b000);
    end

    rng_seq #(.WORDS(WORDS), .SEED_CYCLES(SEED_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_gen(start_gen), .start_seed(start_seed),
        .wide(wide_q), .busy_gen(busy_gen), .busy_seed(busy_seed), .adv(adv),
        .mix(mix), .word_we(word_we), .word_idx(word_idx), .gen_done(gen_done),
        .seed_done(seed_done), .seeded(seeded)
    );

    rng_lfsr #(.POLY(POLY), .INIT(SEED_INIT), .FILL(LOCK_FILL)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .adv(adv), .mix(mix), .noise(noise_in),
        .next_state(next_state), .lock_evt(lock_evt)
    );

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q <= 1'b0;
            ien_q  <= '0;
            areq_q <= '0;
            aage_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == OFS_MODE) wide_q <= bus_wdata[B_WIDE];
            if (bus_addr == OFS_IEN)  ien_q  <= bus_wdata & IEN_MASK;
            if (bus_addr == OFS_AREQ) areq_q <= bus_wdata;
            if (bus_addr == OFS_AAGE) aage_q <= bus_wdata;
        end
    end

    // Event flags: hardware set wins over a same-cycle W1C clear.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 3'b000;
        else        evt_q <= (evt_q & ~evt_clr) | {lock_evt, seed_done, gen_done};
    end

    // One result word register per slot, loaded with the fresh LFSR state.
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                              word_q[g] <= '0;
            else if (word_we && word_idx == IDX_W'(g)) word_q[g] <= next_state;
        end
    end

    // Read multiplexer.
    always_comb begin
        in_words  = (bus_addr >= OFS_WORD0) && (bus_addr < OFS_WORD0 + ADDR_W'(4 * WORDS));
        bus_rdata = '0;
        if (in_words) begin
            bus_rdata = word_q[bus_addr[IDX_W+1:2]];
        end else begin
            case (bus_addr)
                OFS_STAT: begin
                    bus_rdata[B_WIDE]    = wide_q;
                    bus_rdata[B_SEEDED]  = seeded;
                    bus_rdata[B_GENBUSY] = busy_gen;
                    bus_rdata[B_SEEDBSY] = busy_seed;
                end
                OFS_MODE: bus_rdata[B_WIDE] = wide_q;
                OFS_IEN:  bus_rdata = ien_q;
                OFS_EVT: begin
                    bus_rdata[B_RDY]   = evt_q[0];
                    bus_rdata[B_SDONE] = evt_q[1];
                    bus_rdata[B_LOCK]  = evt_q[2];
                end
                OFS_AREQ: bus_rdata = areq_q;
                OFS_AAGE: bus_rdata = aage_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    p_ready_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gen_done |=> evt_q[0]);
    p_seed_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seed_done |=> (evt_q[1] && seeded));
    p_unseeded_words_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_gen && !seeded && !busy_seed) |=> $stable(word_q[0]));
    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien_q[B_GLOBAL] && (evt_q != 3'b000)));
endmodule

// File: tb/tb_rng_ctrl.sv
`timescale 1ns/1ps
module tb_rng_ctrl;
    localparam logic [31:0] POLY = 32'h04C1_1DB7;
    localparam logic [31:0] FILL = 32'h0000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] noise_in = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [31:0] ms;
    logic [31:0] mw [8];

    always #2 clk = ~clk;

    rng_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .noise_in(noise_in), .irq(irq)
    );

    function automatic logic [31:0] stp(input logic [31:0] s);
        return {s[30:0], 1'b0} ^ (s[31] ? POLY : 32'h0);
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    // Count negedges with either busy bit set.
    task automatic busy_len(output int n);
        logic [31:0] v;
        n = 0;
        peek(8'h04, v);
        while ((v[31] || v[30]) && n < 200) begin
            n++;
            @(negedge clk);
            peek(8'h04, v);
        end
        @(negedge clk);
    endtask

    task automatic model_seed(output logic lock);
        lock = 1'b0;
        for (int i = 0; i < 16; i++) begin
            ms = stp(ms) ^ noise_in;
            if (ms == 32'h0) begin ms = FILL; lock = 1'b1; end
        end
    endtask

    task automatic model_gen(input int n);
        for (int i = 0; i < n; i++) begin
            ms = stp(ms);
            mw[i] = ms;
        end
    endtask

    task automatic check_words(input string req);
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            peek(8'h20 + 8'(4 * i), v);
            check(req, $sformatf("word%0d", i), v, mw[i]);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic lk;
        int n;
        ms = 32'hACE1_2468;
        for (int i = 0; i < 8; i++) mw[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(8'h04, v); check("R1", "status", v, 32'h0);
        peek(8'h08, v); check("R1", "mode", v, 32'h0);
        peek(8'h10, v); check("R1", "ien", v, 32'h0);
        peek(8'h14, v); check("R1", "events", v, 32'h0);
        check("R1", "irq", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check_words("R1");

        // R7 generate before seeding
        wr(8'h10, 32'h8000_0013);
        wr(8'h00, 32'd1);
        peek(8'h04, v); check("R7", "status after early gen", v, 32'h0);
        @(negedge clk);
        peek(8'h14, v); check("R7", "events after early gen", v, 32'h0);
        @(negedge clk);
        check_words("R7");

        // R3 reseed
        noise_in = 32'h1357_9BDF;
        wr(8'h00, 32'd2);
        busy_len(n); check("R3", "reseed cycles", n, 16);
        model_seed(lk);
        peek(8'h04, v); check("R3", "status seeded", v, 32'h0000_0200);
        peek(8'h14, v); check("R3", "seed-done flag", v, 32'h2);
        check("R10", "irq on seed-done", {31'h0, irq}, 32'h1);
        @(negedge clk);

        // R9 write-one-to-clear
        wr(8'h14, 32'h0);
        peek(8'h14, v); check("R9", "write zero keeps flag", v, 32'h2);
        @(negedge clk);
        wr(8'h14, 32'h2);
        peek(8'h14, v); check("R9", "write one clears", v, 32'h0);
        check("R10", "irq low after clear", {31'h0, irq}, 32'h0);
        @(negedge clk);

        // R4/R5 128-bit generate
        wr(8'h00, 32'd1);
        busy_len(n); check("R5", "narrow gen cycles", n, 4);
        model_gen(4);
        check_words("R4");
        peek(8'h14, v); check("R4", "ready flag", v, 32'h1);
        @(negedge clk);

        // R5 256-bit generate
        wr(8'h08, 32'h8);
        peek(8'h04, v); check("R5", "status wide bit", v, 32'h0000_0208);
        @(negedge clk);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'd1);
        busy_len(n); check("R4", "wide gen cycles", n, 8);
        model_gen(8);
        check_words("R5");

        // R6 commands while busy
        noise_in = 32'h2468_ACE0;
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'd2);
        wr(8'h00, 32'd1);
        wr(8'h00, 32'd2);
        busy_len(n); check("R6", "remaining reseed cycles", n, 14);
        model_seed(lk);
        check_words("R6");
        peek(8'h14, v); check("R6", "only seed flag", v, 32'h2);
        @(negedge clk);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'd1);
        busy_len(n);
        model_gen(8);
        check_words("R6");

        // R10 interrupt gating (ready flag pending)
        wr(8'h10, 32'h0000_0001);
        peek(8'h10, v); check("R10", "no global, irq", {31'h0, irq}, 32'h0);
        @(negedge clk);
        wr(8'h10, 32'h8000_0002);
        peek(8'h10, v); check("R10", "wrong source, irq", {31'h0, irq}, 32'h0);
        @(negedge clk);
        wr(8'h10, 32'h8000_0001);
        peek(8'h10, v); check("R10", "matching source, irq", {31'h0, irq}, 32'h1);
        @(negedge clk);

        // R12 readback masks
        wr(8'h10, 32'hFFFF_FFFF);
        peek(8'h10, v); check("R12", "ien mask", v, 32'h8000_0013);
        @(negedge clk);
        wr(8'h08, 32'hFFFF_FFFF);
        peek(8'h08, v); check("R12", "mode mask", v, 32'h0000_0008);
        @(negedge clk);

        // R11 auto registers
        wr(8'h60, 32'hDEAD_BEEF);
        wr(8'h64, 32'h0BAD_F00D);
        peek(8'h60, v); check("R11", "auto request", v, 32'hDEAD_BEEF);
        peek(8'h64, v); check("R11", "auto age", v, 32'h0BAD_F00D);
        @(negedge clk);
        wr(8'h00, 32'd1);
        busy_len(n);
        model_gen(8);
        check_words("R11");
        wr(8'h60, 32'h0);
        wr(8'h64, 32'h0);

        // R2 other command codes
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'd0);
        peek(8'h04, v); check("R2", "code 0 idle", v, 32'h0000_0208);
        @(negedge clk);
        wr(8'h00, 32'd3);
        peek(8'h04, v); check("R2", "code 3 idle", v, 32'h0000_0208);
        peek(8'h00, v); check("R2", "ctrl reads 0", v, 32'h0);
        peek(8'h14, v); check("R2", "no flags", v, 32'h0);
        @(negedge clk);
        check_words("R2");

        // R8 lock-up: first reseed step produces zero
        noise_in = stp(ms);
        wr(8'h00, 32'd2);
        busy_len(n); check("R8", "reseed cycles", n, 16);
        model_seed(lk);
        check("R8", "model lock expected", {31'h0, lk}, 32'h1);
        peek(8'h14, v); check("R8", "lock and seed flags", v, 32'h12);
        @(negedge clk);
        wr(8'h00, 32'd1);
        busy_len(n);
        model_gen(8);
        check_words("R8");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule